// File: doc/BRIEF.md
# Threshold Binarizer with Binary Max Pooling

This block sits at the tail of a binary network datapath. It takes signed accumulated sums, one per output pixel of a channel, and compares each against a per-channel threshold. The threshold already contains the effect of batch normalization, so a single signed comparison replaces scaling, shifting and the sign function. A polarity bit per channel chooses the direction of the comparison. A negative normalization scale turns "at or above" into "at or below".

The binary result then either leaves the block directly or goes through 2x2 max pooling with stride 2. For one-bit values, max pooling is a logical OR. The caller supplies the column index and whether the current row is the upper or the lower row of a pooling window. The block keeps one partial bit per output column, covering the upper row, and emits a pooled bit only when the lower-right pixel of a window arrives. A layer-start pulse empties the partial storage. Both paths have a fixed latency of two clock cycles.

Top module: `bin_pool_unit`

## Requirements
- R1: While reset is held, and on release, `out_valid` and `out_bit` are 0.
- R2: With `in_neg` = 0, the binary result is 1 exactly when `in_sum` >= `in_thr`, both read as signed two's complement values of width ACC_W; otherwise it is 0.
- R3: With `in_neg` = 1, the binary result is 1 exactly when `in_sum` <= `in_thr` (signed); otherwise it is 0.
- R4: With `pool_en` = 0, every valid input gives `out_valid` = 1, with `out_bit` equal to its binary result, two clock edges after the input is sampled.
- R5: With `pool_en` = 1, a valid input with `row_odd` = 1 and an odd `col_idx` (bit 0 = 1) gives `out_valid` = 1 two edges later. The accompanying `out_bit` is the OR of four binary results: columns 2c and 2c+1 of the preceding `row_odd` = 0 row, and the same two columns of the current row.
- R6: With `pool_en` = 1, valid inputs at any other window position (upper row, or even column) give `out_valid` = 0.
- R7: A `layer_start` pulse, sampled together with an input, clears all partial window bits before that input is applied. Upper-row bits stored before the pulse therefore do not reach any later pooled output.
- R8: When `in_valid` is 0, `out_valid` is 0 two edges later. Back-to-back valid inputs produce results on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| layer_start | input | 1 | Clears the partial pooling bits |
| in_valid | input | 1 | Input sample valid |
| in_sum | input | ACC_W | Signed accumulated sum |
| in_thr | input | ACC_W | Signed folded threshold for the channel |
| in_neg | input | 1 | 1 = negative scale, compare at-or-below |
| pool_en | input | 1 | 1 = 2x2 OR pooling, 0 = bypass |
| row_odd | input | 1 | 1 = lower row of the pooling window |
| col_idx | input | log2(MAX_COLS) | Input column index |
| out_bit | output | 1 | Binary activation or pooled bit |
| out_valid | output | 1 | Output valid |

## Verification
The comparison is tried against a table of sum and threshold pairs. The pairs include the equal case, values one apart on either side, negative values, and the extreme signed values. The table is run under both polarities, so that swapped operands, an unsigned compare or a strict comparison each produce a wrong bit. Pooling is tried with windows that hold no 1 and windows that hold a single 1 in each of the four corners, so that a missing OR term or a corner assigned to the wrong window shows up. Two interleaved windows check that the per-column storage stays separate. A sequence with a layer start in the middle of a window shows whether stale upper-row bits leak into the result. Back-to-back bypass samples check the two-cycle latency and the ordering.

// File: rtl/binpool_pkg.sv
package binpool_pkg;

    // Position of an input pixel inside its 2x2 pooling window
    typedef enum logic [1:0] {
        WIN_UL = 2'b00,
        WIN_UR = 2'b01,
        WIN_LL = 2'b10,
        WIN_LR = 2'b11
    } win_pos_e;

    function automatic win_pos_e win_pos(input logic row_odd, input logic col_odd);
        return win_pos_e'({row_odd, col_odd});
    endfunction

endpackage

// File: rtl/thr_compare.sv
module thr_compare #(
    parameter int ACC_W = 12,
    parameter int COL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [ACC_W-1:0] in_sum,
    input  logic signed [ACC_W-1:0] in_thr,
    input  logic                    in_neg,
    input  logic                    in_pool,
    input  logic                    in_start,
    input  logic                    in_row_odd,
    input  logic [COL_W-1:0]        in_col,
    output logic                    vld_q,
    output logic                    bin_q,
    output logic                    pool_q,
    output logic                    start_q,
    output logic                    row_odd_q,
    output logic [COL_W-1:0]        col_q
);

    typedef struct packed {
        logic             vld;
        logic             bin;
        logic             pool;
        logic             start;
        logic             row_odd;
        logic [COL_W-1:0] col;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    at_or_above, at_or_below;

    always_comb begin
        at_or_above   = (in_sum >= in_thr);
        at_or_below   = (in_sum <= in_thr);
        st_d          = st_q;
        st_d.vld      = in_valid;
        st_d.bin      = in_valid & (in_neg ? at_or_below : at_or_above);
        st_d.pool     = in_pool;
        st_d.start    = in_start;
        st_d.row_odd  = in_row_odd;
        st_d.col      = in_col;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_q     = st_q.vld;
    assign bin_q     = st_q.bin;
    assign pool_q    = st_q.pool;
    assign start_q   = st_q.start;
    assign row_odd_q = st_q.row_odd;
    assign col_q     = st_q.col;

    // R2
    pos_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_neg) |=> (bin_q == ($past(in_sum) >= $past(in_thr))));

    // R3
    neg_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_neg) |=> (bin_q == ($past(in_sum) <= $past(in_thr))));

endmodule

// File: rtl/or_pool.sv
module or_pool
    import binpool_pkg::*;
#(
    parameter int MAX_COLS = 16,
    parameter int COL_W    = $clog2(MAX_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             bin,
    input  logic             pool,
    input  logic             start,
    input  logic             row_odd,
    input  logic [COL_W-1:0] col,
    output logic             out_valid,
    output logic             out_bit
);

    localparam int OUT_COLS = MAX_COLS / 2;
    localparam int OC_W     = COL_W - 1;

    typedef struct packed {
        logic [OUT_COLS-1:0] part;
        logic                ov;
        logic                ob;
    } pool_st_t;

    pool_st_t            st_d, st_q;
    logic [OC_W-1:0]     pair;
    logic [OUT_COLS-1:0] hit;
    logic [OUT_COLS-1:0] base;
    logic                base_bit;
    win_pos_e            pos;

    assign pair = col[COL_W-1:1];

    for (genvar g = 0; g < OUT_COLS; g++) begin : g_hit
        assign hit[g] = (pair == OC_W'(g));
    end

    always_comb begin
        st_d     = st_q;
        st_d.ov  = 1'b0;
        st_d.ob  = 1'b0;
        base     = start ? '0 : st_q.part;
        base_bit = |(base & hit);
        pos      = win_pos(row_odd, col[0]);
        st_d.part = base;
        if (vld && pool) begin
            for (int i = 0; i < OUT_COLS; i++) begin
                if (hit[i]) begin
                    unique case (pos)
                        WIN_UL:         st_d.part[i] = bin;
                        WIN_UR, WIN_LL: st_d.part[i] = base[i] | bin;
                        WIN_LR:         st_d.part[i] = 1'b0;
                    endcase
                end
            end
            if (pos == WIN_LR) begin
                st_d.ov = 1'b1;
                st_d.ob = base_bit | bin;
            end
        end else if (vld) begin
            st_d.ov = 1'b1;
            st_d.ob = bin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_bit   = st_q.ob;

    // R4
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !pool) |=> (out_valid && out_bit == $past(bin)));

    // R5
    pool_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && pool && row_odd && col[0]) |=> out_valid);

    // R6
    pool_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && pool && !(row_odd && col[0])) |=> !out_valid);

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && vld && pool && row_odd && col[0]) |=> (out_bit == $past(bin)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> !out_valid);

endmodule

// File: rtl/bin_pool_unit.sv
module bin_pool_unit #(
    parameter int ACC_W    = 12,
    parameter int MAX_COLS = 16,
    localparam int COL_W   = $clog2(MAX_COLS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    layer_start,
    input  logic                    in_valid,
    input  logic signed [ACC_W-1:0] in_sum,
    input  logic signed [ACC_W-1:0] in_thr,
    input  logic                    in_neg,
    input  logic                    pool_en,
    input  logic                    row_odd,
    input  logic [COL_W-1:0]        col_idx,
    output logic                    out_bit,
    output logic                    out_valid
);

    logic             s1_vld, s1_bin, s1_pool, s1_start, s1_row_odd;
    logic [COL_W-1:0] s1_col;

    thr_compare #(
        .ACC_W (ACC_W),
        .COL_W (COL_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sum     (in_sum),
        .in_thr     (in_thr),
        .in_neg     (in_neg),
        .in_pool    (pool_en),
        .in_start   (layer_start),
        .in_row_odd (row_odd),
        .in_col     (col_idx),
        .vld_q      (s1_vld),
        .bin_q      (s1_bin),
        .pool_q     (s1_pool),
        .start_q    (s1_start),
        .row_odd_q  (s1_row_odd),
        .col_q      (s1_col)
    );

    or_pool #(
        .MAX_COLS (MAX_COLS),
        .COL_W    (COL_W)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (s1_vld),
        .bin       (s1_bin),
        .pool      (s1_pool),
        .start     (s1_start),
        .row_odd   (s1_row_odd),
        .col       (s1_col),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_bit));

endmodule

// File: tb/bin_pool_unit_test.sv
module bin_pool_unit_test;

    localparam int ACC_W    = 12;
    localparam int MAX_COLS = 16;
    localparam int COL_W    = $clog2(MAX_COLS);

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    layer_start;
    logic                    in_valid;
    logic signed [ACC_W-1:0] in_sum;
    logic signed [ACC_W-1:0] in_thr;
    logic                    in_neg;
    logic                    pool_en;
    logic                    row_odd;
    logic [COL_W-1:0]        col_idx;
    logic                    out_bit;
    logic                    out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bin_pool_unit #(.ACC_W(ACC_W), .MAX_COLS(MAX_COLS)) uut (
        .clk(clk), .rst_n(rst_n), .layer_start(layer_start), .in_valid(in_valid),
        .in_sum(in_sum), .in_thr(in_thr), .in_neg(in_neg), .pool_en(pool_en),
        .row_odd(row_odd), .col_idx(col_idx), .out_bit(out_bit), .out_valid(out_valid)
    );

    typedef struct packed {
        logic signed [ACC_W-1:0] sum;
        logic signed [ACC_W-1:0] thr;
        logic                    neg;
        logic                    exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{ 12'sd5,     12'sd5,    1'b0, 1'b1},
        '{ 12'sd4,     12'sd5,    1'b0, 1'b0},
        '{ 12'sd6,     12'sd5,    1'b0, 1'b1},
        '{-12'sd3,    -12'sd4,    1'b0, 1'b1},
        '{-12'sd4,    -12'sd3,    1'b0, 1'b0},
        '{ 12'sd2047, -12'sd2048, 1'b0, 1'b1},
        '{-12'sd2048,  12'sd2047, 1'b0, 1'b0},
        '{ 12'sd5,     12'sd5,    1'b1, 1'b1},
        '{ 12'sd6,     12'sd5,    1'b1, 1'b0},
        '{-12'sd10,   -12'sd2,    1'b1, 1'b1},
        '{-12'sd2048,  12'sd2047, 1'b1, 1'b1},
        '{ 12'sd2047, -12'sd2048, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // One sample, outputs settled at the negedge after the second posedge
    task automatic apply(input logic signed [ACC_W-1:0] s, input logic signed [ACC_W-1:0] t,
                         input logic ng, input logic pe, input logic ro,
                         input int col, input logic ls);
        in_sum = s; in_thr = t; in_neg = ng; pool_en = pe; row_odd = ro;
        col_idx = COL_W'(col); layer_start = ls; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; layer_start = 1'b0;
        @(negedge clk);
    endtask

    // Pooled pixel with binary value b (threshold 0, positive polarity)
    task automatic pix(input logic b, input logic ro, input int col, input logic ls);
        apply(b ? 12'sd1 : -12'sd1, 12'sd0, 1'b0, 1'b1, ro, col, ls);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; layer_start = 1'b0; in_valid = 1'b0; in_sum = '0; in_thr = '0;
        in_neg = 1'b0; pool_en = 1'b0; row_odd = 1'b0; col_idx = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", out_valid, 1'b0);
        check("R1 bit in reset", out_bit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", out_valid, 1'b0);

        // Table walk in bypass mode: R2 rows have neg=0, R3 rows have neg=1
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].sum, VECS[i].thr, VECS[i].neg, 1'b0, 1'b0, i % MAX_COLS, 1'b0);
            check("R4 bypass valid", out_valid, 1'b1);
            check(VECS[i].neg ? "R3 compare" : "R2 compare", out_bit, VECS[i].exp);
        end

        // R8: back-to-back bypass samples, ordering and latency
        in_sum = 12'sd9; in_thr = 12'sd1; in_neg = 1'b0; pool_en = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_sum = 12'sd0; in_thr = 12'sd1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 first valid", out_valid, 1'b1);
        check("R8 first bit", out_bit, 1'b1);
        @(negedge clk);
        check("R8 second valid", out_valid, 1'b1);
        check("R8 second bit", out_bit, 1'b0);
        @(negedge clk);
        check("R8 idle valid", out_valid, 1'b0);

        // R5/R6: window at cols 0..1, only lower-right set
        pix(1'b0, 1'b0, 0, 1'b1); check("R6 UL quiet", out_valid, 1'b0);
        pix(1'b0, 1'b0, 1, 1'b0); check("R6 UR quiet", out_valid, 1'b0);
        pix(1'b0, 1'b1, 0, 1'b0); check("R6 LL quiet", out_valid, 1'b0);
        pix(1'b1, 1'b1, 1, 1'b0);
        check("R5 emit valid", out_valid, 1'b1);
        check("R5 LR only", out_bit, 1'b1);

        // All zero window
        pix(1'b0, 1'b0, 0, 1'b0); pix(1'b0, 1'b0, 1, 1'b0);
        pix(1'b0, 1'b1, 0, 1'b0); pix(1'b0, 1'b1, 1, 1'b0);
        check("R5 zero window", out_bit, 1'b0);

        // Interleaved windows: UL set at cols 2..3, UR set at cols 6..7, LL set at cols 4..5
        pix(1'b1, 1'b0, 2, 1'b0); pix(1'b0, 1'b0, 3, 1'b0);
        pix(1'b0, 1'b0, 4, 1'b0); pix(1'b0, 1'b0, 5, 1'b0);
        pix(1'b0, 1'b0, 6, 1'b0); pix(1'b1, 1'b0, 7, 1'b0);
        pix(1'b0, 1'b1, 2, 1'b0); pix(1'b0, 1'b1, 3, 1'b0);
        check("R5 UL window", out_bit, 1'b1);
        pix(1'b1, 1'b1, 4, 1'b0); pix(1'b0, 1'b1, 5, 1'b0);
        check("R5 LL window", out_bit, 1'b1);
        pix(1'b0, 1'b1, 6, 1'b0); pix(1'b0, 1'b1, 7, 1'b0);
        check("R5 UR window", out_bit, 1'b1);
        check("R6 emit valid", out_valid, 1'b1);

        // R7: stale upper-row bit cleared by layer start
        pix(1'b1, 1'b0, 8, 1'b0); pix(1'b1, 1'b0, 9, 1'b0);
        pix(1'b0, 1'b1, 8, 1'b1); pix(1'b0, 1'b1, 9, 1'b0);
        check("R7 cleared window valid", out_valid, 1'b1);
        check("R7 cleared window bit", out_bit, 1'b0);

        // R8: no valid input, no output
        repeat (3) @(negedge clk);
        check("R8 quiet", out_valid, 1'b0);

        finish_run();
    end

endmodule